// File: doc/BRIEF.md
# CAN receive buffer allocator

This block decides where a received CAN frame goes once the acceptance filters have judged it. On the completion strobe for a frame it looks at the filter hit vector, picks the first receive buffer that is neither locked by software nor still holding an unread frame, and issues a one-cycle write enable for that buffer. It also records the number of the filter that matched, sets the buffer's ready bit, and raises a receive interrupt pulse when receive interrupts are enabled.

When every buffer is busy, the frame is dropped. An overrun interrupt pulse is raised if overruns are enabled. The identifier of every accepted frame, including a dropped one, is kept in a last-identifier register until the next accepted frame replaces it. Frames that this node sent itself are processed only while self-reception is enabled. Software frees a buffer by pulsing its ready-clear bit. Up to three frames can therefore wait with no CPU action.

All outputs are registered and change on the clock edge that samples the completion strobe.

Top module: `can_rx_alloc`

## Requirements
- R1: After reset, all ready bits, write enables and interrupt pulses are 0, and the last identifier and the recorded filter number are 0.
- R2: A strobed frame whose filter hit vector is all zero is ignored. No write, no interrupt and no change to ready bits, filter number or last identifier occur.
- R3: An accepted frame is written to the lowest-indexed buffer (bit 0 searched first, then 1, then 2) whose lock input and ready bit are both 0. `buf_wr_o` is one-hot, for exactly one cycle, in the cycle after the strobe edge.
- R4: The recorded filter number is the index of the lowest set bit of the hit vector. It appears on `acc_num_o` and in the written buffer's field of `buf_acc_o` (field b at bits b*FW upward, FW = 2 by default).
- R5: The written buffer's ready bit becomes 1 together with its write enable. It stays 1 until its bit of `rdy_clr_i` is pulsed. Other buffers' fields and ready bits are unchanged.
- R6: `rx_irq_o` pulses with a write only when `rx_ie_i` is 1.
- R7: When no buffer is free, no write occurs and the ready bits are unchanged. `ovr_irq_o` pulses only when `ovr_ie_i` is 1.
- R8: `last_id_o` loads the identifier of every accepted frame, dropped ones included, and otherwise holds.
- R9: A frame flagged as the node's own transmission is ignored unless `self_rx_en_i` is 1. With self-reception on, it is handled like any other frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done_i | input | 1 | One-cycle strobe: a received frame is complete |
| frame_id_i | input | ID_W (11) | Identifier of the completed frame |
| filt_hit_i | input | NFILT (4) | Per-filter match results for the frame |
| frame_own_i | input | 1 | Frame was transmitted by this node |
| self_rx_en_i | input | 1 | Allow reception of own frames |
| rx_ie_i | input | 1 | Receive interrupt enable |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| buf_lock_i | input | NBUF (3) | Software lock per buffer |
| rdy_clr_i | input | NBUF (3) | Pulse to clear a buffer's ready bit |
| buf_wr_o | output | NBUF (3) | One-hot write enable to the chosen buffer |
| buf_rdy_o | output | NBUF (3) | Ready bit per buffer |
| buf_acc_o | output | NBUF*FW (6) | Recorded filter number per buffer |
| acc_num_o | output | FW (2) | Filter number of the latest write |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| ovr_irq_o | output | 1 | Overrun interrupt pulse |
| last_id_o | output | ID_W (11) | Identifier of the latest accepted frame |

## Verification
The hardest case to reach is a free buffer that sits above a busy one. The search order only shows when a lower buffer is unavailable, for one reason or the other, and a higher one is free. The bench builds this in two ways. First it locks buffer 0 with all ready bits clear. Then it fills all three buffers and frees only buffers 0 and 1 through the ready-clear pulses, so that buffer 0 must win over buffer 1. Overrun is reached by filling every buffer and then sending frames with the overrun enable on and off. Each time the bench confirms that the ready bits and the recorded filter fields did not move.

// File: rtl/can_rxa_pkg.sv
package can_rxa_pkg;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/can_rxa_first.sv
module can_rxa_first #(
   parameter int unsigned N  = 3,
   parameter int unsigned IW = 2
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      any = |req;
   end

endmodule

// File: rtl/can_rxa_status.sv
module can_rxa_status #(
   parameter int unsigned NBUF = 3,
   parameter int unsigned FW   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NBUF-1:0]    wr,
   input  logic [FW-1:0]      acc_in,
   input  logic [NBUF-1:0]    clr,
   output logic [NBUF-1:0]    rdy,
   output logic [NBUF*FW-1:0] acc_flat
);

   for (genvar b = 0; b < NBUF; b++) begin : g_buf
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdy[b]             <= 1'b0;
            acc_flat[b*FW +: FW] <= '0;
         end else if (wr[b]) begin
            rdy[b]             <= 1'b1;
            acc_flat[b*FW +: FW] <= acc_in;
         end else if (clr[b]) begin
            rdy[b]             <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/can_rx_alloc.sv
module can_rx_alloc
   import can_rxa_pkg::*;
#(
   parameter int unsigned NBUF  = 3,
   parameter int unsigned NFILT = 4,
   parameter int unsigned ID_W  = 11,
   localparam int unsigned FW   = idx_w(NFILT),
   localparam int unsigned BW   = idx_w(NBUF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_done_i,
   input  logic [ID_W-1:0]    frame_id_i,
   input  logic [NFILT-1:0]   filt_hit_i,
   input  logic               frame_own_i,
   input  logic               self_rx_en_i,
   input  logic               rx_ie_i,
   input  logic               ovr_ie_i,
   input  logic [NBUF-1:0]    buf_lock_i,
   input  logic [NBUF-1:0]    rdy_clr_i,
   output logic [NBUF-1:0]    buf_wr_o,
   output logic [NBUF-1:0]    buf_rdy_o,
   output logic [NBUF*FW-1:0] buf_acc_o,
   output logic [FW-1:0]      acc_num_o,
   output logic               rx_irq_o,
   output logic               ovr_irq_o,
   output logic [ID_W-1:0]    last_id_o
);

   if (NBUF < 1 || NFILT < 1 || ID_W < 1) begin : g_bad_cfg
      $error("can_rx_alloc: NBUF, NFILT and ID_W must all be at least 1");
   end

   logic            take;
   logic [NBUF-1:0] free_vec;
   logic [BW-1:0]   buf_idx;
   logic            buf_any;
   logic [FW-1:0]   filt_idx;
   logic            filt_any;
   logic [NBUF-1:0] wr_nxt;

   assign free_vec = ~(buf_lock_i | buf_rdy_o);

   can_rxa_first #(.N(NBUF), .IW(BW)) u_bufsel (
      .req (free_vec),
      .idx (buf_idx),
      .any (buf_any)
   );

   can_rxa_first #(.N(NFILT), .IW(FW)) u_filtsel (
      .req (filt_hit_i),
      .idx (filt_idx),
      .any (filt_any)
   );

   assign take   = frame_done_i && filt_any && (!frame_own_i || self_rx_en_i);
   assign wr_nxt = (take && buf_any) ? (NBUF'(1) << buf_idx) : '0;

   can_rxa_status #(.NBUF(NBUF), .FW(FW)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_nxt),
      .acc_in   (filt_idx),
      .clr      (rdy_clr_i),
      .rdy      (buf_rdy_o),
      .acc_flat (buf_acc_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_wr_o  <= '0;
         acc_num_o <= '0;
         rx_irq_o  <= 1'b0;
         ovr_irq_o <= 1'b0;
         last_id_o <= '0;
      end else begin
         buf_wr_o  <= wr_nxt;
         rx_irq_o  <= take && buf_any && rx_ie_i;
         ovr_irq_o <= take && !buf_any && ovr_ie_i;
         if (take) last_id_o <= frame_id_i;
         if (take && buf_any) acc_num_o <= filt_idx;
      end
   end

endmodule

// File: rtl/can_rx_alloc_chk.sv
module can_rx_alloc_chk #(
   parameter int unsigned NBUF = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            frame_done_i,
   input logic [NBUF-1:0] buf_lock_i,
   input logic [NBUF-1:0] rdy_clr_i,
   input logic [NBUF-1:0] buf_wr_o,
   input logic [NBUF-1:0] buf_rdy_o,
   input logic            rx_irq_o,
   input logic            ovr_irq_o
);

   // R3
   wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(buf_wr_o));

   // R3
   wr_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|buf_wr_o) |-> $past(frame_done_i));

   // R3
   wr_target_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|buf_wr_o) |-> ((buf_wr_o & $past(buf_rdy_o | buf_lock_i)) == '0));

   // R5
   wr_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr_o & ~buf_rdy_o) == '0);

   // R5
   rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(buf_rdy_o) & ~$past(rdy_clr_i) & ~buf_rdy_o) == '0);

   // R6
   rx_irq_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq_o |-> (|buf_wr_o));

   // R7
   ovr_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_irq_o |-> (buf_wr_o == '0));

endmodule

bind can_rx_alloc can_rx_alloc_chk #(.NBUF(NBUF)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_done_i (frame_done_i),
   .buf_lock_i   (buf_lock_i),
   .rdy_clr_i    (rdy_clr_i),
   .buf_wr_o     (buf_wr_o),
   .buf_rdy_o    (buf_rdy_o),
   .rx_irq_o     (rx_irq_o),
   .ovr_irq_o    (ovr_irq_o)
);

// File: tb/can_rx_alloc_bench.sv
`timescale 1ns/1ps
module can_rx_alloc_bench;

   localparam int NBUF = 3;
   localparam int NFILT = 4;
   localparam int ID_W = 11;
   localparam int FW = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             frame_done_i = 1'b0;
   logic [ID_W-1:0]  frame_id_i = '0;
   logic [NFILT-1:0] filt_hit_i = '0;
   logic             frame_own_i = 1'b0;
   logic             self_rx_en_i = 1'b0;
   logic             rx_ie_i = 1'b1;
   logic             ovr_ie_i = 1'b1;
   logic [NBUF-1:0]  buf_lock_i = '0;
   logic [NBUF-1:0]  rdy_clr_i = '0;
   logic [NBUF-1:0]  buf_wr_o;
   logic [NBUF-1:0]  buf_rdy_o;
   logic [NBUF*FW-1:0] buf_acc_o;
   logic [FW-1:0]    acc_num_o;
   logic             rx_irq_o;
   logic             ovr_irq_o;
   logic [ID_W-1:0]  last_id_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   can_rx_alloc u_can_rx_alloc (
      .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done_i), .frame_id_i(frame_id_i),
      .filt_hit_i(filt_hit_i), .frame_own_i(frame_own_i), .self_rx_en_i(self_rx_en_i),
      .rx_ie_i(rx_ie_i), .ovr_ie_i(ovr_ie_i), .buf_lock_i(buf_lock_i), .rdy_clr_i(rdy_clr_i),
      .buf_wr_o(buf_wr_o), .buf_rdy_o(buf_rdy_o), .buf_acc_o(buf_acc_o), .acc_num_o(acc_num_o),
      .rx_irq_o(rx_irq_o), .ovr_irq_o(ovr_irq_o), .last_id_o(last_id_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // strobe one frame; returns with outputs of that strobe visible
   task automatic send(input int id, input int hits, input bit own);
      @(negedge clk);
      frame_id_i   = ID_W'(id);
      filt_hit_i   = NFILT'(hits);
      frame_own_i  = own;
      frame_done_i = 1'b1;
      @(negedge clk);
      frame_done_i = 1'b0;
      filt_hit_i   = '0;
      frame_own_i  = 1'b0;
   endtask

   task automatic clear_rdy(input int mask);
      @(negedge clk);
      rdy_clr_i = NBUF'(mask);
      @(negedge clk);
      rdy_clr_i = '0;
   endtask

   function automatic int acc_of(input int b);
      return int'(buf_acc_o[b*FW +: FW]);
   endfunction

   task automatic t_reset();
      check("R1", "rdy", buf_rdy_o, 0);
      check("R1", "wr", buf_wr_o, 0);
      check("R1", "irqs", {rx_irq_o, ovr_irq_o}, 0);
      check("R1", "last_id", last_id_o, 0);
      check("R1", "acc_num", acc_num_o, 0);
   endtask

   task automatic t_fill();
      send(11'h101, 4'b0100, 1'b0);
      check("R3", "wr first", buf_wr_o, 3'b001);
      check("R4", "acc_num", acc_num_o, 2);
      check("R6", "rx_irq", rx_irq_o, 1);
      check("R8", "last_id", last_id_o, 11'h101);
      send(11'h202, 4'b1010, 1'b0);
      check("R3", "wr second", buf_wr_o, 3'b010);
      check("R4", "acc lowest hit", acc_num_o, 1);
      send(11'h303, 4'b1000, 1'b0);
      check("R3", "wr third", buf_wr_o, 3'b100);
      check("R5", "rdy all", buf_rdy_o, 3'b111);
      check("R4", "acc fields", {acc_of(2), acc_of(1), acc_of(0)}, {32'd3, 32'd1, 32'd2});
      @(negedge clk);
      check("R3", "wr pulse ends", buf_wr_o, 0);
      check("R5", "rdy held", buf_rdy_o, 3'b111);
   endtask

   task automatic t_overrun();
      ovr_ie_i = 1'b1;
      send(11'h155, 4'b0001, 1'b0);
      check("R7", "no wr", buf_wr_o, 0);
      check("R7", "ovr_irq", ovr_irq_o, 1);
      check("R7", "rx_irq", rx_irq_o, 0);
      check("R8", "last_id dropped", last_id_o, 11'h155);
      check("R7", "rdy kept", buf_rdy_o, 3'b111);
      check("R7", "acc kept", acc_of(0), 2);
      ovr_ie_i = 1'b0;
      send(11'h2AA, 4'b0001, 1'b0);
      check("R7", "ovr masked", ovr_irq_o, 0);
      check("R8", "last_id second", last_id_o, 11'h2AA);
      ovr_ie_i = 1'b1;
   endtask

   task automatic t_nohit();
      send(11'h7FF, 4'b0000, 1'b0);
      check("R2", "wr", buf_wr_o, 0);
      check("R2", "ovr", ovr_irq_o, 0);
      check("R2", "last_id", last_id_o, 11'h2AA);
   endtask

   task automatic t_order();
      clear_rdy(3'b111);
      check("R5", "rdy cleared", buf_rdy_o, 0);
      buf_lock_i = 3'b001;
      rx_ie_i = 1'b0;
      send(11'h044, 4'b0010, 1'b0);
      check("R3", "locked skipped", buf_wr_o, 3'b010);
      check("R6", "rx masked", rx_irq_o, 0);
      check("R5", "acc others kept", acc_of(0), 2);
      buf_lock_i = 3'b000;
      rx_ie_i = 1'b1;
      send(11'h045, 4'b0001, 1'b0);
      send(11'h046, 4'b0001, 1'b0);
      check("R5", "rdy full", buf_rdy_o, 3'b111);
      clear_rdy(3'b011);
      send(11'h047, 4'b1000, 1'b0);
      check("R3", "lowest of two free", buf_wr_o, 3'b001);
      check("R4", "acc field 0", acc_of(0), 3);
      clear_rdy(3'b111);
   endtask

   task automatic t_self();
      self_rx_en_i = 1'b0;
      send(11'h321, 4'b0001, 1'b1);
      check("R9", "own ignored wr", buf_wr_o, 0);
      check("R9", "own ignored id", last_id_o, 11'h047);
      check("R9", "own ignored rdy", buf_rdy_o, 0);
      self_rx_en_i = 1'b1;
      send(11'h322, 4'b0100, 1'b1);
      check("R9", "own accepted", buf_wr_o, 3'b001);
      check("R9", "own id", last_id_o, 11'h322);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_fill();
      t_overrun();
      t_nohit();
      t_order();
      t_self();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule